// File: doc/BRIEF.md
# Slave-Port Arbitration Configuration Bank

This block holds the configuration for one slave port of a multi-master crossbar. It has two registers. The priority register gives each master a priority field, and the control register carries an arbitration-mode field and a sticky lock bit. The current contents leave the block on dedicated outputs and feed the port's arbiter directly.

Software reaches the registers through a simple single-beat bus. The bus carries a request strobe, a write enable, a byte offset, a size code, a supervisor flag and write data. Every request is answered exactly one cycle later with an acknowledge, an error flag and read data. Only supervisor word transfers are legal, and any other transfer is refused with an error. Setting the lock bit freezes both registers until the next reset. After that, every write fails with an error and reads still return the stored values.

Top module: `arb_cfg_bank`

## Requirements
- R1: After reset the priority register reads 0x7654_3210, the control register reads 0, `pri_o` holds value m in master m's field, `mode_o` is 0 and `locked_o` is 0.
- R2: A legal write at offset 0x00 stores, for each master m, bits [4m+2:4m] of the write data. The register reads back with every other bit zero.
- R3: A legal write at offset 0x10 stores bits [1:0] as the arbitration mode. The control register reads back with the lock at bit 31, the mode at bits [1:0] and all other bits zero.
- R4: A request with `priv_i` low (user mode) is answered with an error and zero read data, and it changes no register or exported value.
- R5: A request whose size code is not word (2'b10; byte is 2'b00, half is 2'b01, 2'b11 is undefined) is answered with an error and zero read data, and it has no side effect.
- R6: A legal write to the control register with bit 31 set makes `locked_o` high. From then on every write fails with an error and changes nothing, and legal reads still return the stored values without error.
- R7: The lock can only be cleared by reset. Writing 0 to bit 31 does not set it, and a reset restores every reset value of R1.
- R8: Every offset other than 0x00 and 0x10, including unaligned ones, is reserved. A legal read there returns zero without error, and a write there fails with an error and has no effect.
- R9: Each request is acknowledged in the next cycle for exactly one cycle. The error flag is only ever high together with the acknowledge, and write acknowledges carry zero read data.
- R10: `pri_o`, `mode_o` and `locked_o` show the effect of an accepted write from the cycle in which its acknowledge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the port window |
| size_i | input | 2 | Transfer size code (2'b10 = word) |
| priv_i | input | 1 | 1 = supervisor access |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access acknowledge, one cycle after request |
| err_o | output | 1 | Error response, valid with ack_o |
| rdata_o | output | 32 | Read data, valid with ack_o |
| pri_o | output | NUM_MASTERS*PRI_W | Packed per-master priority fields |
| mode_o | output | MODE_W | Arbitration mode field |
| locked_o | output | 1 | Configuration frozen until reset |

## Verification
A corrupted register shows up on the exported outputs in the same cycle, because those outputs come straight from the state with no read needed. The same fault also shows up in the read data one cycle after any legal read. The acknowledge path is different. A wrong decode or a wrong lock state does not appear until a request is made, and it then shows in the single response cycle as a missing or spurious error or as a changed export. For this reason the sweep covers every offset under every combination of size, privilege and direction, and it compares the response and the exports after each access.

// File: rtl/arb_cfg_pkg.sv
// Shared types for the slave-port arbitration configuration bank.
// Assumes a 32-bit register data path.
package arb_cfg_pkg;
    localparam int DATA_W = 32;

    // Bus size codes; only word transfers are legal.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_UNDEF = 2'b11
    } xfer_size_e;

    // Register selected by the offset decode.
    typedef enum logic [1:0] {
        TGT_PRI  = 2'b00,
        TGT_CTRL = 2'b01,
        TGT_NONE = 2'b10
    } tgt_e;
endpackage

// File: rtl/arb_cfg_decode.sv
// Access decode and legality check.
// Picks the register addressed by the offset and decides whether the access
// is refused: user mode, non-word size, a write to a reserved offset, or any
// write while locked. Produces write strobes only for accepted writes.
// Assumes offsets are compared on the full address, so unaligned ones miss.
module arb_cfg_decode
    import arb_cfg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PRI_OFS  = 0,
    parameter int CTRL_OFS = 16
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              priv_i,
    input  logic              locked_i,
    output tgt_e              tgt_o,
    output logic              wr_pri_o,
    output logic              wr_ctrl_o,
    output logic              fault_o
);
    logic legal;
    logic wr_allowed;

    // Offset decode: select the register or mark the offset reserved.
    always_comb begin
        tgt_o = TGT_NONE;
        if (addr_i == ADDR_W'(PRI_OFS)) begin
            tgt_o = TGT_PRI;
        end else if (addr_i == ADDR_W'(CTRL_OFS)) begin
            tgt_o = TGT_CTRL;
        end
    end

    // Legality: supervisor word access, writes also need a target and no lock.
    always_comb begin
        legal      = priv_i && (xfer_size_e'(size_i) == SZ_WORD);
        wr_allowed = legal && !locked_i && (tgt_o != TGT_NONE);
        fault_o    = req_i && (!legal || (we_i && !wr_allowed));
        wr_pri_o   = req_i && we_i && wr_allowed && (tgt_o == TGT_PRI);
        wr_ctrl_o  = req_i && we_i && wr_allowed && (tgt_o == TGT_CTRL);
    end
endmodule

// File: rtl/arb_cfg_regs.sv
// Register storage for the priority and control registers.
// Each master owns a PRI_W-bit field placed at the bottom of its slot of
// DATA_W/NUM_MASTERS bits; field m resets to m. The control register keeps
// a MODE_W-bit mode at the bottom and a sticky lock bit at LOCK_BIT.
// Assumes write strobes are already qualified by the decode.
module arb_cfg_regs
    import arb_cfg_pkg::*;
#(
    parameter int NUM_MASTERS = 8,
    parameter int PRI_W       = 3,
    parameter int MODE_W      = 2,
    parameter int LOCK_BIT    = 31
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_pri_i,
    input  logic                         wr_ctrl_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [NUM_MASTERS*PRI_W-1:0] pri_flat_o,
    output logic [DATA_W-1:0]            pri_img_o,
    output logic [DATA_W-1:0]            ctrl_img_o,
    output logic [MODE_W-1:0]            mode_o,
    output logic                         locked_o
);
    localparam int STRIDE = DATA_W / NUM_MASTERS;

    logic [PRI_W-1:0] fld [NUM_MASTERS];
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_field
        // Per-master priority field: reset to its own index, load on write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld[m] <= PRI_W'(m);
            end else if (wr_pri_i) begin
                fld[m] <= wdata_i[m*STRIDE +: PRI_W];
            end
        end
        assign pri_flat_o[m*PRI_W +: PRI_W] = fld[m];
    end

    // Read image of the priority register with unimplemented bits zero.
    always_comb begin
        pri_img_o = '0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            pri_img_o[m*STRIDE +: PRI_W] = fld[m];
        end
    end

    // Arbitration mode field: load on accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
        end else if (wr_ctrl_i) begin
            mode_o <= wdata_i[MODE_W-1:0];
        end
    end

    // Lock bit: set by writing 1, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
        end else if (wr_ctrl_i && wdata_i[LOCK_BIT]) begin
            locked_o <= 1'b1;
        end
    end

    // Read image of the control register.
    always_comb begin
        ctrl_img_o               = '0;
        ctrl_img_o[MODE_W-1:0]   = mode_o;
        ctrl_img_o[LOCK_BIT]     = locked_o;
    end
endmodule

// File: rtl/arb_cfg_bank.sv
// Configuration bank for one crossbar slave port.
// Answers every request with a registered one-cycle acknowledge, error flag
// and read data. Refused accesses return zero data and change nothing.
// Exports the live register contents to the port arbiter.
// Assumes req_i is a single-cycle strobe per access.
module arb_cfg_bank
    import arb_cfg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_MASTERS = 8,
    parameter int PRI_W       = 3,
    parameter int MODE_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic                         we_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [1:0]                   size_i,
    input  logic                         priv_i,
    input  logic [31:0]                  wdata_i,
    output logic                         ack_o,
    output logic                         err_o,
    output logic [31:0]                  rdata_o,
    output logic [NUM_MASTERS*PRI_W-1:0] pri_o,
    output logic [MODE_W-1:0]            mode_o,
    output logic                         locked_o
);
    localparam int PRI_OFS  = 0;
    localparam int CTRL_OFS = 16;
    localparam int LOCK_BIT = DATA_W - 1;

    tgt_e              tgt;
    logic              wr_pri;
    logic              wr_ctrl;
    logic              fault;
    logic [DATA_W-1:0] pri_img;
    logic [DATA_W-1:0] ctrl_img;
    logic [DATA_W-1:0] rd_mux;

    arb_cfg_decode #(
        .ADDR_W   (ADDR_W),
        .PRI_OFS  (PRI_OFS),
        .CTRL_OFS (CTRL_OFS)
    ) u_decode (
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .size_i    (size_i),
        .priv_i    (priv_i),
        .locked_i  (locked_o),
        .tgt_o     (tgt),
        .wr_pri_o  (wr_pri),
        .wr_ctrl_o (wr_ctrl),
        .fault_o   (fault)
    );

    arb_cfg_regs #(
        .NUM_MASTERS (NUM_MASTERS),
        .PRI_W       (PRI_W),
        .MODE_W      (MODE_W),
        .LOCK_BIT    (LOCK_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pri_i   (wr_pri),
        .wr_ctrl_i  (wr_ctrl),
        .wdata_i    (wdata_i),
        .pri_flat_o (pri_o),
        .pri_img_o  (pri_img),
        .ctrl_img_o (ctrl_img),
        .mode_o     (mode_o),
        .locked_o   (locked_o)
    );

    // Read select: reserved offsets read as zero.
    always_comb begin
        unique case (tgt)
            TGT_PRI:  rd_mux = pri_img;
            TGT_CTRL: rd_mux = ctrl_img;
            default:  rd_mux = '0;
        endcase
    end

    // Response register: one-cycle acknowledge with error and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o   <= req_i;
            err_o   <= fault;
            rdata_o <= (req_i && !we_i && !fault) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/arb_cfg_bank_chk.sv
// Port-level property checker for arb_cfg_bank, bound to every instance.
module arb_cfg_bank_chk #(
    parameter int ADDR_W      = 8,
    parameter int NUM_MASTERS = 8,
    parameter int PRI_W       = 3,
    parameter int MODE_W      = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_i,
    input logic                         we_i,
    input logic [ADDR_W-1:0]            addr_i,
    input logic [1:0]                   size_i,
    input logic                         priv_i,
    input logic [31:0]                  wdata_i,
    input logic                         ack_o,
    input logic                         err_o,
    input logic [31:0]                  rdata_o,
    input logic [NUM_MASTERS*PRI_W-1:0] pri_o,
    input logic [MODE_W-1:0]            mode_o,
    input logic                         locked_o
);
    logic unused_chk;
    logic legal;
    logic rsvd;

    assign unused_chk = ^wdata_i;
    assign legal = priv_i && (size_i == 2'b10);
    assign rsvd  = (addr_i != ADDR_W'(0)) && (addr_i != ADDR_W'(16));

    a_r9_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ack_o);
    a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !ack_o);
    a_r9_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ack_o);
    a_r4_user_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !priv_i) |=> (err_o && rdata_o == 32'd0
            && $stable(pri_o) && $stable(mode_o) && $stable(locked_o)));
    a_r5_size_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i != 2'b10) |=> (err_o && $stable(pri_o)
            && $stable(mode_o) && $stable(locked_o)));
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);
    a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> ($stable(pri_o) && $stable(mode_o)));
    a_r6_locked_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && locked_o) |=> err_o);
    a_r8_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && legal && rsvd) |=> (!err_o && rdata_o == 32'd0));
    a_r8_rsvd_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && rsvd) |=> err_o);
    a_r3_mode_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && legal && !locked_o && addr_i == ADDR_W'(16))
            |=> (mode_o == $past(wdata_i[MODE_W-1:0])));
    a_r2_field0_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && legal && !locked_o && addr_i == ADDR_W'(0))
            |=> (pri_o[PRI_W-1:0] == $past(wdata_i[PRI_W-1:0])));
endmodule

bind arb_cfg_bank arb_cfg_bank_chk #(
    .ADDR_W      (ADDR_W),
    .NUM_MASTERS (NUM_MASTERS),
    .PRI_W       (PRI_W),
    .MODE_W      (MODE_W)
) u_chk (.*);

// File: tb/arb_cfg_bank_tb.sv
module arb_cfg_bank_tb;
    localparam int NM = 8;
    localparam int PW = 3;
    localparam int MW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic            we_i = 1'b0;
    logic [7:0]      addr_i = '0;
    logic [1:0]      size_i = '0;
    logic            priv_i = 1'b0;
    logic [31:0]     wdata_i = '0;
    logic            ack_o;
    logic            err_o;
    logic [31:0]     rdata_o;
    logic [NM*PW-1:0] pri_o;
    logic [MW-1:0]   mode_o;
    logic            locked_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model of the register contents.
    logic [31:0] m_pri;
    logic [MW-1:0] m_mode;
    logic m_lock;

    arb_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .size_i(size_i), .priv_i(priv_i),
        .wdata_i(wdata_i), .ack_o(ack_o), .err_o(err_o),
        .rdata_o(rdata_o), .pri_o(pri_o), .mode_o(mode_o),
        .locked_o(locked_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NM*PW-1:0] exp_flat();
        logic [NM*PW-1:0] f;
        for (int m = 0; m < NM; m++) f[m*PW +: PW] = m_pri[m*4 +: PW];
        return f;
    endfunction

    task automatic check_exports(input string tag);
        check(tag, 64'(pri_o), 64'(exp_flat()), "pri_o");
        check(tag, 64'(mode_o), 64'(m_mode), "mode_o");
        check(tag, 64'(locked_o), 64'(m_lock), "locked_o");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pri = 32'h7654_3210;
        m_mode = '0;
        m_lock = 1'b0;
    endtask

    // One access: compute expected response from the model, then compare.
    task automatic access(input logic we, input logic [7:0] a,
                          input logic [1:0] sz, input logic pv,
                          input logic [31:0] wd, input string force_tag);
        logic ok, hp, hc, e_err;
        logic [31:0] e_rd;
        string tag;
        ok = pv && (sz == 2'b10);
        hp = (a == 8'h00);
        hc = (a == 8'h10);
        e_err = 1'b0;
        e_rd = '0;
        if (!pv) tag = "R4";
        else if (sz != 2'b10) tag = "R5";
        else if (!(hp || hc)) tag = "R8";
        else if (m_lock && we) tag = "R6";
        else if (hc) tag = "R3";
        else tag = "R2";
        if (force_tag != "") tag = force_tag;
        if (!ok) begin
            e_err = 1'b1;
        end else if (we) begin
            if (!(hp || hc) || m_lock) e_err = 1'b1;
        end else begin
            e_rd = hp ? m_pri : hc ? {m_lock, 29'd0, m_mode} : 32'd0;
        end
        @(negedge clk);
        req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; priv_i = pv; wdata_i = wd;
        @(posedge clk);
        #1;
        if (ok && we && !e_err) begin
            if (hp) m_pri = wd & 32'h7777_7777;
            else begin
                m_mode = wd[MW-1:0];
                if (wd[31]) m_lock = 1'b1;
            end
        end
        check(tag, 64'(ack_o), 64'd1, "ack");
        check(tag, 64'(err_o), 64'(e_err), "err");
        check(tag, 64'(rdata_o), 64'(e_rd), "rdata");
        check_exports("R10");
        @(negedge clk);
        req_i = 1'b0;
        @(posedge clk);
        #1;
        check("R9", 64'({ack_o, err_o}), 64'd0, "idle ack/err");
    endtask

    initial begin
        do_reset();
        @(posedge clk);
        #1;
        check_exports("R1");
        check("R1", 64'(ack_o), 64'd0, "ack after reset");
        access(1'b0, 8'h00, 2'b10, 1'b1, 32'd0, "R1");
        access(1'b0, 8'h10, 2'b10, 1'b1, 32'd0, "R1");

        // Unlocked sweep over every offset, size, privilege and direction.
        for (int a = 0; a < 256; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int pv = 0; pv < 2; pv++) begin
                    for (int we = 0; we < 2; we++) begin
                        logic [31:0] wd;
                        wd = 32'h9E37_79B9 * 32'(a*16 + sz*4 + pv*2 + we + 1);
                        wd[31] = 1'b0;
                        access(we[0], 8'(a), sz[1:0], pv[0], wd, "");
                    end
                end
            end
        end

        // Writing 0 to the lock bit leaves it clear.
        access(1'b1, 8'h10, 2'b10, 1'b1, 32'h7FFF_FFFE, "R7");
        access(1'b0, 8'h10, 2'b10, 1'b1, 32'd0, "R7");
        access(1'b1, 8'h00, 2'b10, 1'b1, 32'h0123_4567, "R2");
        access(1'b0, 8'h00, 2'b10, 1'b1, 32'd0, "R2");

        // Lock together with a mode change, then attempt every kind of write.
        access(1'b1, 8'h10, 2'b10, 1'b1, 32'h8000_0001, "R6");
        for (int i = 0; i < 4; i++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int pv = 0; pv < 2; pv++) begin
                    for (int we = 0; we < 2; we++) begin
                        logic [7:0] a;
                        a = (i == 0) ? 8'h00 : (i == 1) ? 8'h10 : (i == 2) ? 8'h20 : 8'h11;
                        access(we[0], a, sz[1:0], pv[0],
                               32'hA5C3_96E1 ^ 32'(i*64 + sz*8 + pv*2 + we), "");
                    end
                end
            end
        end
        access(1'b1, 8'h10, 2'b10, 1'b1, 32'h0000_0000, "R7");

        // Only reset releases the lock and restores the reset values.
        do_reset();
        @(posedge clk);
        #1;
        check_exports("R7");
        access(1'b0, 8'h00, 2'b10, 1'b1, 32'd0, "R7");
        access(1'b0, 8'h10, 2'b10, 1'b1, 32'd0, "R7");
        access(1'b1, 8'h10, 2'b10, 1'b1, 32'h0000_0003, "R7");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule